// File: doc/BRIEF.md
# Embedded-Sync Video Input Controller

This block follows a digital video sample stream in the video clock domain and turns it into capture control for a downstream formatter. It works in one of four modes. In the two embedded-sync modes (8-bit and 16-bit) it searches the stream for timing reference codes and ancillary data packets, and decodes field, vertical blanking and line boundaries from them. In external-sync mode it takes frame and line timing from separate horizontal and vertical sync pins. In raw streaming mode it does not parse the data and marks each sample with a pass-through valid.

Every sample passes through a short tag pipeline. This lets the block remove the three preamble words of a timing code from the active-video stream after the code has been recognised. All outputs for a given sample appear together, four clocks after that sample is taken. The mode and capture-request inputs may come from another clock domain, so they are resynchronised first. Capture starts and stops only on frame boundaries.

Top module: `vid_in_ctrl`

## Requirements
- R1: While reset is held and right after it, every valid, pulse and status output is 0 (field_odd, vblank and cap_active included).
- R2: In an embedded mode, the sequence FF, 00, 00 followed by a status byte on the parsed lane is a timing code. Bit 6 of the status byte gives field_odd and bit 5 gives vblank. Both values are shown on the status byte and on every following sample until the next code.
- R3: Bit 4 of the status byte marks the end of a line when 1 and the start of a line when 0. The block pulses line_end or line_start on the status byte. The two pulses are never asserted together.
- R4: After a start-of-line code with bit 5 clear, each sample is marked act_valid. This stops before the next code: neither its three preamble words nor its status byte are active. A start-of-line code with bit 5 set produces no active samples. Each output appears 4 clocks after its input sample.
- R5: Outside an active line, the sequence 00, FF, FF starts an ancillary packet. The block marks anc_valid on the data ID, the secondary ID, the count byte and exactly count payload bytes, and not on the preamble or on anything after the packet. A count of 0 ends the packet after the count byte. act_valid, anc_valid and raw_valid are mutually exclusive.
- R6: An ancillary preamble that appears inside an active line is treated as video and does not start a packet.
- R7: A timing code whose field bit is 0 while the previous field was 1 is a frame boundary and pulses frame_start on its status byte.
- R8: cap_active takes the resynchronised cap_req level only at a frame boundary. cap_start pulses when it rises there and cap_stop when it falls. A request that drops and returns between two boundaries has no effect. act_valid and anc_valid occur only while capture is active.
- R9: cfg_mode 0 selects 8-bit embedded mode: bits 7:0 are parsed and pix_data carries zeros in bits 15:8. cfg_mode 1 selects 16-bit embedded mode: bits 15:8 are parsed and pix_data carries all 16 bits.
- R10: cfg_mode 2 selects external sync. A falling vsync is a frame boundary and toggles field_odd. vblank follows vsync. act_valid is set for samples with hsync high and vsync low. A rising hsync pulses line_start and a falling hsync pulses line_end.
- R11: cfg_mode 3 selects raw streaming. raw_valid follows the resynchronised cap_req on every sample, and no timing code, line or frame event is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Mode select (0 emb8, 1 emb16, 2 external sync, 3 raw), resynchronised |
| cfg_capture | input | 1 | Capture request level, resynchronised |
| vid_data | input | 16 | Incoming sample |
| vid_hsync | input | 1 | External horizontal sync, high during active samples |
| vid_vsync | input | 1 | External vertical sync, high during vertical blanking |
| pix_data | output | 16 | Sample data aligned with the flags |
| act_valid | output | 1 | Active video sample |
| anc_valid | output | 1 | Ancillary packet byte |
| raw_valid | output | 1 | Raw streaming sample |
| line_start | output | 1 | Start-of-line pulse |
| line_end | output | 1 | End-of-line pulse |
| frame_start | output | 1 | Frame boundary pulse |
| field_odd | output | 1 | Current field |
| vblank | output | 1 | Vertical blanking flag |
| cap_active | output | 1 | Capture is running |
| cap_start | output | 1 | Capture started at this boundary |
| cap_stop | output | 1 | Capture stopped at this boundary |

## Verification
The bench builds the block with its default parameters: a 16-bit sample bus, two synchroniser stages and an 8-bit packet counter. The four-stage tag pipeline follows from the three-word preamble, so every sample can be compared against its expected flags at a fixed latency. The bench runs each of the four modes from reset. It covers vertical-blanking and active lines in both field orders, ancillary packets with a count of 3 and of 0, a packet preamble embedded in video, and capture requests that toggle between frame boundaries. The 8-bit mode is driven with junk in the unused lane so that any lane mix-up shows in pix_data.

// File: rtl/vin_pkg.sv
package vin_pkg;
  localparam int VID_W   = 16;
  localparam int LANE_W  = 8;
  localparam int PRE_LEN = 3;

  typedef enum logic [1:0] {
    MODE_EMB8  = 2'd0,
    MODE_EMB16 = 2'd1,
    MODE_EXT   = 2'd2,
    MODE_RAW   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_BLANK, S_ACT, S_SDID, S_DC, S_PAY
  } pst_e;

  // Per-sample tag carried down the alignment pipeline
  typedef struct packed {
    logic [VID_W-1:0] data;
    logic act;
    logic anc;
    logic raw;
    logic ls;
    logic le;
    logic fs;
    logic fld;
    logic vbl;
    logic cap;
    logic cs;
    logic cp;
  } tag_t;

  function automatic logic [LANE_W-1:0] lane_byte(input logic [VID_W-1:0] d, input mode_e m);
    return (m == MODE_EMB16) ? d[VID_W-1:LANE_W] : d[LANE_W-1:0];
  endfunction

  function automatic logic [VID_W-1:0] out_word(input logic [VID_W-1:0] d, input mode_e m);
    return (m == MODE_EMB8) ? {{(VID_W-LANE_W){1'b0}}, d[LANE_W-1:0]} : d;
  endfunction

  // oldest, middle, newest history bytes
  function automatic logic is_trs(input logic [LANE_W-1:0] o, input logic [LANE_W-1:0] m,
                                  input logic [LANE_W-1:0] n);
    return (o == '1) && (m == '0) && (n == '0);
  endfunction

  function automatic logic is_anc_pre(input logic [LANE_W-1:0] o, input logic [LANE_W-1:0] m,
                                      input logic [LANE_W-1:0] n);
    return (o == '0) && (m == '1) && (n == '1);
  endfunction
endpackage

// File: rtl/vin_cfg_sync.sv
module vin_cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/vin_parser.sv
module vin_parser
  import vin_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             cap_req,
  input  logic [VID_W-1:0] vid_data,
  input  logic             hs,
  input  logic             vs,
  output tag_t             ent,
  output logic             kill,
  output logic             trs_hit,
  output logic             anc_hit,
  output logic             frame_edge
);
  logic [LANE_W-1:0] hist [PRE_LEN];
  logic [LANE_W-1:0] b;
  pst_e              st;
  logic [CNT_W-1:0]  cnt;
  logic              fld, vbl, cap, hs_q, vs_q;
  logic              emb, ext, vs_fall, hs_rise, hs_fall;
  logic              fld_nxt, vbl_nxt, cap_nxt, in_pkt;

  assign b       = lane_byte(vid_data, mode);
  assign emb     = (mode == MODE_EMB8) || (mode == MODE_EMB16);
  assign ext     = (mode == MODE_EXT);
  assign trs_hit = emb && is_trs(hist[2], hist[1], hist[0]);
  assign anc_hit = emb && !trs_hit && (st == S_BLANK) && is_anc_pre(hist[2], hist[1], hist[0]);
  assign vs_fall = ext && vs_q && !vs;
  assign hs_rise = ext && hs && !hs_q;
  assign hs_fall = ext && !hs && hs_q;

  assign frame_edge = (trs_hit && fld && !b[6]) || vs_fall;
  assign fld_nxt    = trs_hit ? b[6] : (vs_fall ? !fld : fld);
  assign vbl_nxt    = trs_hit ? b[5] : (ext ? vs : vbl);
  assign cap_nxt    = frame_edge ? cap_req : cap;
  assign in_pkt     = emb && !trs_hit && (anc_hit || st == S_SDID || st == S_DC || st == S_PAY);
  assign kill       = trs_hit;

  always_comb begin
    ent      = '0;
    ent.data = out_word(vid_data, mode);
    ent.act  = cap_nxt && ((emb && st == S_ACT && !trs_hit) || (ext && hs && !vs));
    ent.anc  = cap_nxt && in_pkt;
    ent.raw  = (mode == MODE_RAW) && cap_req;
    ent.ls   = (trs_hit && !b[4]) || hs_rise;
    ent.le   = (trs_hit && b[4]) || hs_fall;
    ent.fs   = frame_edge;
    ent.fld  = fld_nxt;
    ent.vbl  = vbl_nxt;
    ent.cap  = cap_nxt;
    ent.cs   = frame_edge && cap_req && !cap;
    ent.cp   = frame_edge && !cap_req && cap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
      st   <= S_BLANK;
      cnt  <= '0;
      fld  <= 1'b0;
      vbl  <= 1'b0;
      cap  <= 1'b0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hist[0] <= b;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
      fld  <= fld_nxt;
      vbl  <= vbl_nxt;
      cap  <= cap_nxt;
      hs_q <= hs;
      vs_q <= vs;
      if (!emb) begin
        st <= S_BLANK;
      end else if (trs_hit) begin
        st <= (!b[4] && !b[5]) ? S_ACT : S_BLANK;
      end else begin
        case (st)
          S_BLANK: if (anc_hit) st <= S_SDID;
          S_SDID:  st <= S_DC;
          S_DC: begin
            cnt <= CNT_W'(b);
            st  <= (b == '0) ? S_BLANK : S_PAY;
          end
          S_PAY: begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) st <= S_BLANK;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/vin_tagline.sv
module vin_tagline
  import vin_pkg::*;
#(
  parameter int DEPTH = PRE_LEN + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  tag_t ent,
  input  logic kill,
  output tag_t tail
);
  tag_t stg [DEPTH];

  // A recognised timing code strips the active mark from the preamble words in flight
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= ent;
      for (int i = 1; i < DEPTH; i++) begin
        stg[i]     <= stg[i-1];
        stg[i].act <= stg[i-1].act && !kill;
      end
    end
  end

  assign tail = stg[DEPTH-1];
endmodule

// File: rtl/vid_in_ctrl.sv
module vid_in_ctrl
  import vin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_capture,
  input  logic [VID_W-1:0]  vid_data,
  input  logic              vid_hsync,
  input  logic              vid_vsync,
  output logic [VID_W-1:0]  pix_data,
  output logic              act_valid,
  output logic              anc_valid,
  output logic              raw_valid,
  output logic              line_start,
  output logic              line_end,
  output logic              frame_start,
  output logic              field_odd,
  output logic              vblank,
  output logic              cap_active,
  output logic              cap_start,
  output logic              cap_stop
);
  localparam int DEPTH = PRE_LEN + 1;

  logic [2:0] cfg_s;
  tag_t       ent, tail;
  logic       kill, trs_hit, anc_hit, frame_edge;

  vin_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cfg_mode, cfg_capture}), .q(cfg_s)
  );

  vin_parser #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .mode(mode_e'(cfg_s[2:1])), .cap_req(cfg_s[0]),
    .vid_data(vid_data), .hs(vid_hsync), .vs(vid_vsync), .ent(ent), .kill(kill),
    .trs_hit(trs_hit), .anc_hit(anc_hit), .frame_edge(frame_edge)
  );

  vin_tagline #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .ent(ent), .kill(kill), .tail(tail)
  );

  assign pix_data    = tail.data;
  assign act_valid   = tail.act;
  assign anc_valid   = tail.anc;
  assign raw_valid   = tail.raw;
  assign line_start  = tail.ls;
  assign line_end    = tail.le;
  assign frame_start = tail.fs;
  assign field_odd   = tail.fld;
  assign vblank      = tail.vbl;
  assign cap_active  = tail.cap;
  assign cap_start   = tail.cs;
  assign cap_stop    = tail.cp;
endmodule

// File: rtl/vid_in_ctrl_chk.sv
module vid_in_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic act_valid,
  input logic anc_valid,
  input logic raw_valid,
  input logic line_start,
  input logic line_end,
  input logic frame_start,
  input logic cap_active,
  input logic cap_start,
  input logic cap_stop
);
  p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_valid, anc_valid, raw_valid}));

  p_line_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_start && line_end));

  p_act_needs_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid || anc_valid) |-> cap_active);

  p_cap_moves_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_active) |-> frame_start);

  p_start_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start |-> (frame_start && cap_active));

  p_stop_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stop |-> (frame_start && !cap_active));

  p_rise_flags_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_active) |-> cap_start);
endmodule

bind vid_in_ctrl vid_in_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .anc_valid(anc_valid),
  .raw_valid(raw_valid), .line_start(line_start), .line_end(line_end),
  .frame_start(frame_start), .cap_active(cap_active), .cap_start(cap_start),
  .cap_stop(cap_stop)
);

// File: tb/test_vid_in_ctrl.sv
module test_vid_in_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_capture = 1'b0;
  logic [15:0] vid_data = 16'h0010;
  logic        vid_hsync = 1'b0, vid_vsync = 1'b0;
  logic [15:0] pix_data;
  logic act_valid, anc_valid, raw_valid, line_start, line_end, frame_start;
  logic field_odd, vblank, cap_active, cap_start, cap_stop;

  vid_in_ctrl i_vid_in_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_capture(cfg_capture),
    .vid_data(vid_data), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .pix_data(pix_data), .act_valid(act_valid), .anc_valid(anc_valid),
    .raw_valid(raw_valid), .line_start(line_start), .line_end(line_end),
    .frame_start(frame_start), .field_odd(field_odd), .vblank(vblank),
    .cap_active(cap_active), .cap_start(cap_start), .cap_stop(cap_stop)
  );

  localparam int MAXS = 4096;
  localparam int LAT  = 4;
  logic [15:0] e_data  [MAXS];
  logic [10:0] e_flags [MAXS];
  bit          e_chk   [MAXS];
  string       e_req   [MAXS];
  int drv_n = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int m_mode;
  bit m_fld, m_vbl, m_cap, m_req, m_inact, m_hs, m_vs;

  function automatic logic [10:0] mk(input bit a, input bit n, input bit r, input bit ls,
                                     input bit le, input bit fs, input bit cs, input bit cp);
    return {a, n, r, ls, le, fs, m_fld, m_vbl, m_cap, cs, cp};
  endfunction

  function automatic logic [15:0] lane(input logic [7:0] b, input logic [7:0] lo);
    return (m_mode == 1) ? {b, lo} : {8'hA5, b};
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] w);
    return (m_mode == 0) ? {8'h00, w[7:0]} : w;
  endfunction

  // Called at a negedge: compare the sample driven LAT pushes ago, then drive a new one
  task automatic push(input logic [15:0] d, input logic hs, input logic vs,
                      input logic [10:0] fl, input logic [15:0] ed, input bit chk, input string rq);
    if (drv_n >= LAT && e_chk[drv_n-LAT]) begin
      int k = drv_n - LAT;
      logic [10:0] got = {act_valid, anc_valid, raw_valid, line_start, line_end, frame_start,
                          field_odd, vblank, cap_active, cap_start, cap_stop};
      n_chk++;
      if (got !== e_flags[k]) begin
        n_bad++;
        $display("FAIL %s sample %0d flags act/anc/raw/ls/le/fs/fld/vbl/cap/cs/cp got %b exp %b",
                 e_req[k], k, got, e_flags[k]);
      end else if ((e_flags[k][10] | e_flags[k][9] | e_flags[k][8]) && pix_data !== e_data[k]) begin
        n_bad++;
        $display("FAIL %s sample %0d pix_data got %h exp %h", e_req[k], k, pix_data, e_data[k]);
      end
    end
    if (drv_n >= MAXS) begin
      n_bad++;
      $display("FAIL bench sample store full got %0d exp below %0d", drv_n, MAXS);
    end else begin
      vid_data = d; vid_hsync = hs; vid_vsync = vs;
      e_flags[drv_n] = fl; e_data[drv_n] = ed; e_chk[drv_n] = chk; e_req[drv_n] = rq;
      drv_n++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input int mode);
    for (int i = 1; i <= LAT && drv_n - i >= 0; i++) e_chk[drv_n-i] = 1'b0;
    rst_n = 1'b0; cfg_mode = 2'(mode); cfg_capture = m_req;
    vid_data = 16'h0010; vid_hsync = 1'b0; vid_vsync = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    n_chk++;
    if ({act_valid, anc_valid, raw_valid, line_start, line_end, frame_start, field_odd,
         vblank, cap_active, cap_start, cap_stop} !== 11'b0) begin
      n_bad++;
      $display("FAIL R1 outputs in reset got %b exp 0", {act_valid, anc_valid, raw_valid,
               line_start, line_end, frame_start, field_odd, vblank, cap_active, cap_start, cap_stop});
    end
    m_mode = mode; m_fld = 0; m_vbl = 0; m_cap = 0; m_inact = 0; m_hs = 0; m_vs = 0;
    rst_n = 1'b1;
  endtask

  task automatic set_req(input bit v);
    m_req = v; cfg_capture = v;
  endtask

  // one parsed byte with no code meaning
  task automatic word(input logic [7:0] b, input logic [7:0] lo, input bit chk, input string rq);
    logic [15:0] d = lane(b, lo);
    push(d, 0, 0, mk(m_inact && m_cap, 0, 0, 0, 0, 0, 0, 0), exp_word(d), chk, rq);
  endtask

  task automatic idle(input int n, input bit chk, input string rq);
    for (int i = 0; i < n; i++) word(8'h10, 8'h80, chk, rq);
  endtask

  task automatic trs(input bit f, input bit v, input bit h, input string rq);
    logic [7:0] pb [3] = '{8'hFF, 8'h00, 8'h00};
    bit bnd, cs_, cp_;
    for (int i = 0; i < 3; i++) push(lane(pb[i], 8'h80), 0, 0, mk(0,0,0,0,0,0,0,0), 16'h0, 1, rq);
    bnd = m_fld && !f;
    cs_ = bnd && m_req && !m_cap;
    cp_ = bnd && !m_req && m_cap;
    if (bnd) m_cap = m_req;
    m_fld = f; m_vbl = v;
    push(lane({1'b1, f, v, h, 4'h0}, 8'h80), 0, 0, mk(0,0,0,!h,h,bnd,cs_,cp_), 16'h0, 1, rq);
    m_inact = !h && !v;
  endtask

  task automatic video(input int n, input string rq);
    for (int i = 0; i < n; i++) word(8'h20 + 8'(i), 8'h90 + 8'(i), 1, rq);
  endtask

  task automatic anc_pkt(input logic [7:0] dc, input string rq);
    logic [7:0] pb [3] = '{8'h00, 8'hFF, 8'hFF};
    logic [7:0] hd [3];
    hd[0] = 8'h41; hd[1] = 8'h42; hd[2] = dc;
    if (m_inact) begin
      // R6: preamble inside an active line is plain video
      for (int i = 0; i < 3; i++) word(pb[i], 8'h80, 1, "R6");
      for (int i = 0; i < 3; i++) word(hd[i], 8'h80, 1, "R6");
    end else begin
      for (int i = 0; i < 3; i++) push(lane(pb[i], 8'h80), 0, 0, mk(0,0,0,0,0,0,0,0), 16'h0, 1, rq);
      for (int i = 0; i < 3; i++) begin
        logic [15:0] d = lane(hd[i], 8'h80);
        push(d, 0, 0, mk(0, m_cap, 0,0,0,0,0,0), exp_word(d), 1, rq);
      end
      for (int i = 0; i < int'(dc); i++) begin
        logic [15:0] d = lane(8'h30 + 8'(i), 8'h80);
        push(d, 0, 0, mk(0, m_cap, 0,0,0,0,0,0), exp_word(d), 1, rq);
      end
    end
  endtask

  task automatic line(input bit f, input bit v, input int n, input string rq);
    trs(f, v, 1'b1, rq);
    idle(3, 1, rq);
    trs(f, v, 1'b0, rq);
    if (!v) video(n, rq);
  endtask

  task automatic ext_s(input bit hs, input bit vs, input logic [7:0] dd, input string rq);
    bit fall, rise, hfall, cs_, cp_;
    fall = m_vs && !vs; rise = hs && !m_hs; hfall = !hs && m_hs;
    cs_ = fall && m_req && !m_cap;
    cp_ = fall && !m_req && m_cap;
    if (fall) begin m_cap = m_req; m_fld = !m_fld; end
    m_vbl = vs;
    push({8'h60, dd}, hs, vs, mk(hs && !vs && m_cap, 0, 0, rise, hfall, fall, cs_, cp_),
         {8'h60, dd}, 1, rq);
    m_hs = hs; m_vs = vs;
  endtask

  task automatic raw_s(input logic [7:0] b, input bit chk, input string rq);
    logic [15:0] d = {8'h5A, b};
    push(d, 0, 0, mk(0, 0, m_req, 0,0,0,0,0), d, chk, rq);
  endtask

  initial begin
    m_req = 0;
    @(negedge clk);
    // ---------------- 8-bit embedded (R9 lane masking throughout)
    do_reset(0);
    idle(6, 1, "R1");
    line(1, 1, 0, "R2");          // blanking line: no active (R4)
    line(1, 0, 6, "R8");          // active line but capture off
    set_req(1); idle(3, 1, "R8");
    trs(0, 0, 1, "R7");           // field 1 -> 0: boundary, capture starts
    idle(2, 1, "R5");
    anc_pkt(8'd3, "R5");
    idle(2, 1, "R5");
    anc_pkt(8'd0, "R5");
    idle(2, 1, "R5");
    trs(0, 0, 0, "R3");
    video(5, "R4");
    anc_pkt(8'd2, "R6");
    video(3, "R9");
    line(0, 1, 0, "R4");
    set_req(0); idle(3, 1, "R8");
    set_req(1); idle(3, 1, "R8");
    line(1, 0, 4, "R8");
    line(0, 0, 4, "R8");          // boundary, request still high: no start pulse
    set_req(0); idle(3, 1, "R8");
    line(1, 0, 4, "R8");          // still capturing until boundary
    line(0, 0, 4, "R8");          // boundary stops capture
    idle(2, 1, "R8");
    // ---------------- 16-bit embedded
    set_req(1);
    do_reset(1);
    idle(5, 1, "R9");
    line(1, 0, 3, "R9");
    line(0, 0, 6, "R9");
    idle(2, 1, "R2");
    line(0, 1, 0, "R2");
    idle(2, 1, "R9");
    // ---------------- external sync
    do_reset(2);
    for (int i = 0; i < 4; i++) ext_s(0, 0, 8'h01, "R10");
    for (int i = 0; i < 3; i++) ext_s(0, 1, 8'h02, "R10");
    for (int j = 0; j < 2; j++) begin
      ext_s(0, 0, 8'h03, "R10");
      for (int i = 0; i < 2; i++) ext_s(0, 0, 8'h04, "R10");
      for (int i = 0; i < 5; i++) ext_s(1, 0, 8'h10 + 8'(i), "R10");
      for (int i = 0; i < 2; i++) ext_s(0, 0, 8'h05, "R10");
      for (int i = 0; i < 2; i++) ext_s(1, 1, 8'h06, "R10");
      for (int i = 0; i < 2; i++) ext_s(0, 1, 8'h07, "R10");
    end
    for (int i = 0; i < 3; i++) ext_s(0, 0, 8'h08, "R10");
    // ---------------- raw streaming
    set_req(0);
    do_reset(3);
    for (int i = 0; i < 4; i++) raw_s(8'h11, 0, "R11");
    raw_s(8'hFF, 1, "R11"); raw_s(8'h00, 1, "R11"); raw_s(8'h00, 1, "R11"); raw_s(8'h80, 1, "R11");
    set_req(1);
    for (int i = 0; i < 3; i++) raw_s(8'h22, 0, "R11");
    raw_s(8'hFF, 1, "R11"); raw_s(8'h00, 1, "R11"); raw_s(8'h00, 1, "R11"); raw_s(8'h90, 1, "R11");
    for (int i = 0; i < 6; i++) raw_s(8'h40 + 8'(i), 1, "R11");
    for (int i = 0; i < LAT; i++) raw_s(8'h33, 0, "R11");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule